// File: doc/BRIEF.md
# Serial Audio Bit and Frame Clock Generator

This block takes a master audio clock and produces two clocks for a serial audio link: a bit clock and a left/right frame clock. The bit clock runs at half or a quarter of the master clock. The frame clock is divided down from the bit clock by 32, 64 or 128. Both run at 50% duty. Every frame clock transition is issued on the same master clock edge as a falling bit clock edge, so a receiver that samples on the rising bit clock edge always sees a stable frame clock.

A single serial enable gates both outputs. While the enable is low, both clocks are held low, all counters are cleared, and the divide selections are copied from the inputs continuously. The first frame after the enable rises therefore starts cleanly with the selections present at that moment. While the block is running, the divide selections are sampled only at a frame boundary, which is the falling frame clock edge. A change made part-way through a frame does not alter that frame.

Top module: `i2s_clkgen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `sclkOut` and `lrclkOut` are both 0.
- R2: On the master clock edge after `serEn` is sampled low, both outputs are 0 and every counter restarts. With `serEn` high, the first rising edge of `sclkOut` comes after 1 enabled edge when the fast bit-clock divide is selected and after 2 enabled edges when the slow divide is selected.
- R3: With `sclkDivSel` = 0 the bit clock is the master clock divided by 2 (1 cycle high, 1 cycle low). With `sclkDivSel` = 1 it is divided by 4 (2 cycles high, 2 cycles low).
- R4: `frameDivSel` selects the frame clock ratio against the bit clock: 2'b00 gives /32, 2'b01 gives /64, 2'b10 gives /128, and 2'b11 also gives /128. The frame clock spends half of the selected number of bit periods in each level.
- R5: Whenever `lrclkOut` changes while enabled, `sclkOut` falls on that same master clock edge.
- R6: After enabling, the frame clock is low for the first half frame. With /2 and /32 it is 0 after 31 enabled edges and 1 after 32.
- R7: A change to `sclkDivSel` or `frameDivSel` while enabled takes effect only at the next falling edge of `lrclkOut`. The frame in progress keeps the old ratios.
- R8: The selections in force on the first enabled edge are the input values present on the last edge at which `serEn` was low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master audio clock; every register runs on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| serEn | input | 1 | Serial enable; low holds both outputs low and clears the dividers |
| sclkDivSel | input | 1 | Bit clock divide: 0 = /2, 1 = /4 |
| frameDivSel | input | 2 | Frame divide code: 00 = /32, 01 = /64, 10 and 11 = /128 |
| sclkOut | output | 1 | Bit clock |
| lrclkOut | output | 1 | Left/right frame clock |

## Verification
The bound checker enforces four rules on every cycle. Both clocks drop after a disabled edge. The frame clock moves only together with a falling bit clock. The bit clock high width matches the divide in force. The frame clock never rises unless the enable was set. Exact periods, the start-of-frame phase after enabling, and the deferral of a selection change to the frame boundary depend on long histories. Only the bench's cycle-by-cycle reference model can show these, as it runs each divide code, toggles the enable, and changes the selections in the middle of a frame.

// File: rtl/i2s_clkgen_pkg.sv
`timescale 1ns/1ps
package i2s_clkgen_pkg;
  // bit periods in one half frame at the shortest ratio (/32)
  localparam int HALF_BITS_MIN = 16;
  localparam int MAX_SHIFT = 2;
  localparam int BIT_CNT_W = $clog2(HALF_BITS_MIN << MAX_SHIFT);
  localparam int PRE_W = 1;

  typedef struct packed {
    logic       clear;
    logic       tick;
    logic [1:0] frameCode;
  } strobe_t;

  // last bit index of a half frame for a frame code; 11 behaves as 10
  function automatic logic [BIT_CNT_W-1:0] lastBitOf(input logic [1:0] code);
    int sh;
    sh = (int'(code) > MAX_SHIFT) ? MAX_SHIFT : int'(code);
    return BIT_CNT_W'((HALF_BITS_MIN << sh) - 1);
  endfunction
endpackage

// File: rtl/i2s_clkgen_ctrl.sv
`timescale 1ns/1ps
module i2s_clkgen_ctrl
  import i2s_clkgen_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    serEn,
  input  logic    sclkDivSel,
  input  logic [1:0] frameDivSel,
  input  logic    frameEnd,
  output strobe_t stb,
  output logic    slowAct
);
  logic [1:0]       codeAct;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLast;
  logic             tickNow;

  assign preLast = slowAct ? PRE_W'(1) : PRE_W'(0);
  assign tickNow = serEn && (preCnt == preLast);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slowAct <= 1'b0;
      codeAct <= 2'b00;
      preCnt  <= '0;
    end else if (!serEn) begin
      slowAct <= sclkDivSel;
      codeAct <= frameDivSel;
      preCnt  <= '0;
    end else begin
      if (tickNow) preCnt <= '0;
      else         preCnt <= preCnt + PRE_W'(1);
      if (frameEnd) begin
        slowAct <= sclkDivSel;
        codeAct <= frameDivSel;
      end
    end
  end

  always_comb begin
    stb.clear     = !serEn;
    stb.tick      = tickNow;
    stb.frameCode = codeAct;
  end
endmodule

// File: rtl/i2s_clkgen_dp.sv
`timescale 1ns/1ps
module i2s_clkgen_dp
  import i2s_clkgen_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  strobe_t stb,
  output logic    sclk,
  output logic    lrclk,
  output logic    frameEnd
);
  logic [BIT_CNT_W-1:0] bitCnt;
  logic [BIT_CNT_W-1:0] lastBit;
  logic                 fallNow;
  logic                 halfDone;

  assign lastBit  = lastBitOf(stb.frameCode);
  assign fallNow  = stb.tick && sclk;
  assign halfDone = fallNow && (bitCnt == lastBit);
  assign frameEnd = halfDone && lrclk;

  always_ff @(posedge clk) begin
    if (!rst_n || stb.clear) begin
      sclk   <= 1'b0;
      lrclk  <= 1'b0;
      bitCnt <= '0;
    end else begin
      if (stb.tick) sclk <= ~sclk;
      if (halfDone) begin
        bitCnt <= '0;
        lrclk  <= ~lrclk;
      end else if (fallNow) begin
        bitCnt <= bitCnt + BIT_CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/i2s_clkgen.sv
`timescale 1ns/1ps
module i2s_clkgen
  import i2s_clkgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       serEn,
  input  logic       sclkDivSel,
  input  logic [1:0] frameDivSel,
  output logic       sclkOut,
  output logic       lrclkOut
);
  strobe_t stb;
  logic    slowAct;
  logic    frameEnd;

  i2s_clkgen_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .serEn(serEn),
    .sclkDivSel(sclkDivSel), .frameDivSel(frameDivSel),
    .frameEnd(frameEnd), .stb(stb), .slowAct(slowAct)
  );

  i2s_clkgen_dp u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .sclk(sclkOut), .lrclk(lrclkOut), .frameEnd(frameEnd)
  );
endmodule

// File: rtl/i2s_clkgen_chk.sv
`timescale 1ns/1ps
module i2s_clkgen_chk (
  input logic clk,
  input logic rst_n,
  input logic serEn,
  input logic sclk,
  input logic lrclk,
  input logic slowAct
);
  a_r2_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !serEn |=> (!sclk && !lrclk));

  a_r5_lr_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(serEn) && (lrclk != $past(lrclk))) |-> (!sclk && $past(sclk)));

  a_r3_fast_high: assert property (@(posedge clk) disable iff (!rst_n)
    (serEn && !slowAct && $past(rst_n) && sclk && !$past(sclk)) |=> !sclk);

  a_r3_slow_high: assert property (@(posedge clk) disable iff (!rst_n)
    (serEn && slowAct && $past(rst_n) && sclk && !$past(sclk)) |=> sclk);

  a_r2_lr_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && lrclk && !$past(lrclk)) |-> $past(serEn));
endmodule

bind i2s_clkgen i2s_clkgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .serEn(serEn),
  .sclk(sclkOut), .lrclk(lrclkOut), .slowAct(slowAct)
);

// File: tb/i2s_clkgen_tb.sv
`timescale 1ns/1ps
module i2s_clkgen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic serEn = 1'b0;
  logic sclkDivSel = 1'b0;
  logic [1:0] frameDivSel = 2'b00;
  logic sclkOut, lrclkOut;

  int compared = 0;
  int mismatched = 0;
  string curReq = "R1";
  bit finished = 0;

  // reference state
  int  n = 0;
  bit  aSlow = 0;
  int  aCode = 0;
  bit  mS = 0, mL = 0;
  bit  lastS = 0, lastL = 0;
  bit  usedEn;

  always #10 clk = ~clk;

  i2s_clkgen u_dut (
    .clk(clk), .rst_n(rst_n), .serEn(serEn),
    .sclkDivSel(sclkDivSel), .frameDivSel(frameDivSel),
    .sclkOut(sclkOut), .lrclkOut(lrclkOut)
  );

  function automatic int halfOf(bit s);
    return s ? 2 : 1;
  endfunction
  function automatic int hfOf(int c);
    return (c == 0) ? 16 : (c == 1) ? 32 : 64;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    usedEn = serEn;
    if (!rst_n) begin
      n = 0; aSlow = 0; aCode = 0;
    end else if (!serEn) begin
      n = 0; aSlow = sclkDivSel; aCode = int'(frameDivSel);
    end else begin
      n++;
      if (n == 4 * halfOf(aSlow) * hfOf(aCode)) begin
        n = 0; aSlow = sclkDivSel; aCode = int'(frameDivSel);
      end
    end
    mS = ((n / halfOf(aSlow)) % 2) == 1;
    mL = (((n / (2 * halfOf(aSlow))) / hfOf(aCode)) % 2) == 1;
    #5;
    check(sclkOut == mS && lrclkOut == mL, curReq,
          int'({sclkOut, lrclkOut}), int'({mS, mL}));
    if (rst_n && usedEn && lrclkOut != lastL)
      check(lastS && !sclkOut, "R5", int'({lastS, sclkOut}), 2);
    lastS = sclkOut;
    lastL = lrclkOut;
  end

  task automatic runCyc(int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual 0 expected 1 (run finished)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    runCyc(3);
    check(sclkOut == 0 && lrclkOut == 0, "R1", int'({sclkOut, lrclkOut}), 0);
    rst_n = 1'b1;
    runCyc(3);

    // R6 and R3: fast bit clock, /32 frame, first half frame low
    curReq = "R3";
    sclkDivSel = 0; frameDivSel = 2'b00;
    @(negedge clk); serEn = 1'b1;
    repeat (31) @(posedge clk);
    #6 check(lrclkOut == 0, "R6", lrclkOut, 0);
    @(posedge clk);
    #6 check(lrclkOut == 1, "R6", lrclkOut, 1);
    runCyc(200);

    // R2: disable mid frame, outputs drop, restart clean
    curReq = "R2";
    @(negedge clk); serEn = 1'b0;
    @(posedge clk);
    #6 check(sclkOut == 0 && lrclkOut == 0, "R2", int'({sclkOut, lrclkOut}), 0);
    runCyc(5);
    sclkDivSel = 1; frameDivSel = 2'b01;
    @(negedge clk); serEn = 1'b1;
    @(posedge clk);
    #6 check(sclkOut == 0, "R2", sclkOut, 0);
    @(posedge clk);
    #6 check(sclkOut == 1, "R2", sclkOut, 1);
    curReq = "R3";
    runCyc(600);

    // R4: remaining frame codes including the reserved one
    curReq = "R4";
    @(negedge clk); serEn = 1'b0;
    sclkDivSel = 0; frameDivSel = 2'b10;
    runCyc(3); serEn = 1'b1;
    runCyc(600);
    @(negedge clk); serEn = 1'b0;
    frameDivSel = 2'b11;
    runCyc(3); serEn = 1'b1;
    runCyc(600);

    // R7: selection change in mid frame waits for the frame boundary
    curReq = "R7";
    @(negedge clk); serEn = 1'b0;
    sclkDivSel = 0; frameDivSel = 2'b00;
    runCyc(3); serEn = 1'b1;
    runCyc(20);
    sclkDivSel = 1; frameDivSel = 2'b01;
    repeat (43) @(posedge clk);
    #6 check(sclkOut == 1 && lrclkOut == 1, "R7", int'({sclkOut, lrclkOut}), 3);
    runCyc(700);
    frameDivSel = 2'b00;
    runCyc(700);

    // R8: selections captured while disabled apply on enabling
    curReq = "R8";
    @(negedge clk); serEn = 1'b0;
    runCyc(4);
    sclkDivSel = 1; frameDivSel = 2'b10;
    @(negedge clk); serEn = 1'b1;
    sclkDivSel = 0; frameDivSel = 2'b00;
    runCyc(1100);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule